// File: doc/BRIEF.md
# Transmit Cell Snapshot Counter

This block counts the data cells that leave the transmit queue and go into outgoing frames. Each accepted cell shows up as a one-cycle strobe. The count is held in a live accumulator of `CNT_W` bits, 24 by default. Fill cells that the framer makes up by itself produce no strobe, so they are never counted.

Software marks the end of an accumulation interval by writing to the snapshot address. That one write copies the live count into a holding register and restarts the live count from zero, both on the same clock edge. Software then reads the held value as two pieces:

- The snapshot address returns the upper part of the held count.
- A second address returns the lower `LO_W` bits, 16 by default.

Read data is combinational from the address. The held value cannot be written from the bus.

Top module: `cellcnt_snapshot`

## Requirements
- R1: After reset, both the live count and the held count are zero, so every read returns zero.
- R2: Each clock cycle with `cell_rd` high adds exactly one to the live count. A cycle without the strobe leaves it unchanged.
- R3: A write with `reg_addr` equal to the snapshot address (default 4'h3) copies the live count, as it stood before that edge, into the holding register. On the same edge it clears the live count. The value of `reg_wdata` has no influence.
- R4: A `cell_rd` strobe in the same cycle as a snapshot write belongs to the new interval. The held value excludes that cell, and the live count becomes 1.
- R5: Read data depends on `reg_addr` as follows:
  - Snapshot address (4'h3): held bits [CNT_W-1:LO_W], zero-extended.
  - Low address (4'h2, default): held bits [LO_W-1:0], zero-extended.
  - Any other address: zero.
  - Read data follows `reg_addr` combinationally.
- R6: The live count stops at its all-ones value (0xFFFFFF by default) and stays there until the next snapshot, instead of wrapping.
- R7: A write to the low address, or to any address other than the snapshot address, changes neither the held count nor the live count.
- R8: The held count changes only on a snapshot write. Cell strobes in between leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_rd | input | 1 | One pulse per data cell taken from the transmit queue |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address for both write and read |
| reg_wdata | input | DATA_W (16) | Write data (has no effect) |
| reg_rdata | output | DATA_W (16) | Read data selected by `reg_addr` |

## Verification
Two instances are tried side by side with the same stimulus: the default 24-bit one and a 12-bit one with an 8-bit low part.

- **Sparse strobes with gaps:** separates counting on strobe cycles from counting on every cycle.
- **Back-to-back snapshots:** show that a snapshot really clears the live count.
- **Snapshot with a cell in the same cycle:** separates the new-interval rule from counting that cell in the old interval, and from dropping it.
- **A long unbroken burst of 70000 cells:** carries a nonzero upper byte on the wide instance and drives the narrow one into saturation. This distinguishes stopping at all-ones from wrapping.
- **Writes to the low address and to unused addresses**, with cells interleaved: confirm that they leave both counts unchanged.

// File: rtl/cellcnt_pkg.sv
package cellcnt_pkg;

   // Which register a bus address selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/cellcnt_accum.sv
// Live cell accumulator with same-edge restart and an optional ceiling.
module cellcnt_accum #(
   parameter int CNT_W    = 24,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   initial begin
      if (CNT_W < 2) $error("cellcnt_accum: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         always_comb cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;

         // R6: the ceiling holds until a snapshot
         p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
      end else begin : g_wrap
         always_comb cnt_inc = cnt + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= inc ? CNT_ONE : '0;
      end else if (inc) begin
         cnt <= cnt_inc;
      end
   end

   // R2: one step per strobe
   p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));

   // R2: no strobe, no change
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt));

   // R3 / R4: restart value after a snapshot
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == (inc_q ? CNT_ONE : '0)));

   logic inc_q;
   always_ff @(posedge clk) inc_q <= inc;

endmodule

// File: rtl/cellcnt_hold.sv
// Snapshot holding register, loaded only on a capture pulse.
module cellcnt_hold #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [CNT_W-1:0] din,
   output logic [CNT_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (cap) begin
         q <= din;
      end
   end

   // R3: capture takes the pre-edge live count
   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (q == $past(din)));

   // R8: nothing but a capture moves the held value
   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(q));

endmodule

// File: rtl/cellcnt_regif.sv
// Address decode for the snapshot trigger and the split read-back.
module cellcnt_regif
   import cellcnt_pkg::*;
#(
   parameter int              ADDR_W  = 4,
   parameter int              DATA_W  = 16,
   parameter int              CNT_W   = 24,
   parameter int              LO_W    = 16,
   parameter logic [ADDR_W-1:0] ADDR_HI = 4'h3,
   parameter logic [ADDR_W-1:0] ADDR_LO = 4'h2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  held,
   output logic              snap,
   output logic [DATA_W-1:0] rdata
);

   localparam int HI_W = CNT_W - LO_W;

   initial begin
      if (LO_W < 1 || LO_W >= CNT_W) $error("cellcnt_regif: LO_W out of range");
      if (LO_W > DATA_W)             $error("cellcnt_regif: LO_W wider than bus");
      if (HI_W > DATA_W)             $error("cellcnt_regif: upper part wider than bus");
      if (ADDR_HI == ADDR_LO)        $error("cellcnt_regif: addresses collide");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] hi_ext;
   logic [DATA_W-1:0] lo_ext;

   always_comb begin
      if (addr == ADDR_HI)      sel = SEL_HI;
      else if (addr == ADDR_LO) sel = SEL_LO;
      else                      sel = SEL_NONE;
   end

   assign snap = wr_en && (sel == SEL_HI);

   always_comb begin
      hi_ext            = '0;
      hi_ext[HI_W-1:0]  = held[CNT_W-1:LO_W];
      lo_ext            = '0;
      lo_ext[LO_W-1:0]  = held[LO_W-1:0];
   end

   always_comb begin
      unique case (sel)
         SEL_HI:  rdata = hi_ext;
         SEL_LO:  rdata = lo_ext;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/cellcnt_snapshot.sv
// Top: transmit cell counter with atomic snapshot-and-clear.
module cellcnt_snapshot #(
   parameter int                ADDR_W   = 4,
   parameter int                DATA_W   = 16,
   parameter int                CNT_W    = 24,
   parameter int                LO_W     = 16,
   parameter bit                SATURATE = 1'b1,
   parameter logic [ADDR_W-1:0] ADDR_HI  = 4'h3,
   parameter logic [ADDR_W-1:0] ADDR_LO  = 4'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_rd,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);

   logic             snap;
   logic [CNT_W-1:0] live_cnt;
   logic [CNT_W-1:0] held_cnt;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata;

   cellcnt_regif #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .LO_W   (LO_W),
      .ADDR_HI(ADDR_HI),
      .ADDR_LO(ADDR_LO)
   ) u_regif (
      .wr_en(reg_wr),
      .addr (reg_addr),
      .held (held_cnt),
      .snap (snap),
      .rdata(reg_rdata)
   );

   cellcnt_accum #(
      .CNT_W   (CNT_W),
      .SATURATE(SATURATE)
   ) u_accum (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cell_rd),
      .clr  (snap),
      .cnt  (live_cnt)
   );

   cellcnt_hold #(
      .CNT_W(CNT_W)
   ) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .cap  (snap),
      .din  (live_cnt),
      .q    (held_cnt)
   );

   // R7: a write elsewhere never reaches the held value
   p_wr_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != ADDR_HI) |=> $stable(held_cnt));

endmodule

// File: tb/sim_cellcnt_snapshot.sv
`timescale 1ns/100ps
module sim_cellcnt_snapshot;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cell_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] rdata0;
   logic [15:0] rdata1;

   int n_chk = 0;
   int n_fail = 0;
   string phase = "R1";

   // reference model state
   longint m_cnt0 = 0, m_buf0 = 0, m_cnt1 = 0, m_buf1 = 0;
   localparam longint MAX0 = 64'hFFFFFF;
   localparam longint MAX1 = 64'hFFF;

   always #2.5 clk = ~clk;

   cellcnt_snapshot u0 (
      .clk(clk), .rst_n(rst_n), .cell_rd(cell_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata0));

   cellcnt_snapshot #(.CNT_W(12), .LO_W(8)) u1 (
      .clk(clk), .rst_n(rst_n), .cell_rd(cell_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata1));

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt0 = 0; m_buf0 = 0; m_cnt1 = 0; m_buf1 = 0;
      end else if (reg_wr && reg_addr == 4'h3) begin
         m_buf0 = m_cnt0; m_buf1 = m_cnt1;
         m_cnt0 = cell_rd ? 1 : 0;
         m_cnt1 = cell_rd ? 1 : 0;
      end else if (cell_rd) begin
         if (m_cnt0 < MAX0) m_cnt0 = m_cnt0 + 1;
         if (m_cnt1 < MAX1) m_cnt1 = m_cnt1 + 1;
      end
   end

   function automatic logic [15:0] expect_rd(longint b, int lo_w, int hi_w, logic [3:0] a);
      if (a == 4'h3) return 16'((b >> lo_w) & ((64'd1 << hi_w) - 1));
      if (a == 4'h2) return 16'(b & ((64'd1 << lo_w) - 1));
      return 16'h0;
   endfunction

   task automatic compare();
      logic [15:0] e0, e1;
      e0 = expect_rd(m_buf0, 16, 8, reg_addr);
      e1 = expect_rd(m_buf1, 8, 4, reg_addr);
      n_chk += 2;
      if (rdata0 !== e0) begin
         n_fail++;
         $display("FAIL %s u0 addr=%h actual=%h expected=%h", phase, reg_addr, rdata0, e0);
      end
      if (rdata1 !== e1) begin
         n_fail++;
         $display("FAIL %s u1 addr=%h actual=%h expected=%h", phase, reg_addr, rdata1, e1);
      end
   endtask

   // one cycle: check outputs at the falling edge, then apply new inputs
   task automatic cyc(input logic c, input logic w, input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      compare();
      cell_rd = c; reg_wr = w; reg_addr = a; reg_wdata = d;
   endtask

   task automatic idle_read(input logic [3:0] a, input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, 16'h0);
   endtask

   task automatic snap_read();
      cyc(1'b0, 1'b1, 4'h3, 16'hBEEF);
      idle_read(4'h3, 2);
      idle_read(4'h2, 2);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5ns * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog %s timeout actual=running expected=done", phase);
      finish_run();
   end

   initial begin
      // R1: reset state on all addresses
      phase = "R1";
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 4'h3, 16'h0);
      cyc(1'b0, 1'b0, 4'h2, 16'h0);
      @(negedge clk); rst_n = 1'b1;
      idle_read(4'h3, 2); idle_read(4'h2, 2); idle_read(4'h7, 2);

      // R2: sparse strobes with gaps
      phase = "R2";
      for (int i = 0; i < 37; i++) begin
         cyc(1'b1, 1'b0, 4'h2, 16'h0);
         cyc(1'b0, 1'b0, 4'h2, 16'h0);
         if (i % 5 == 0) cyc(1'b0, 1'b0, 4'h2, 16'h0);
      end
      snap_read();

      // R3: back-to-back snapshot with no cells gives zero
      phase = "R3";
      for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 4'h2, 16'h0);
      cyc(1'b0, 1'b1, 4'h3, 16'h0000);
      cyc(1'b0, 1'b1, 4'h3, 16'hFFFF);
      idle_read(4'h3, 2); idle_read(4'h2, 2);

      // R4: cell in the snapshot cycle opens the new interval
      phase = "R4";
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 4'h2, 16'h0);
      cyc(1'b1, 1'b1, 4'h3, 16'h1234);
      idle_read(4'h2, 2);
      snap_read();

      // R7: writes to low and unused addresses do nothing
      phase = "R7";
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 4'h2, 16'h0);
      cyc(1'b0, 1'b1, 4'h2, 16'hFFFF);
      cyc(1'b1, 1'b1, 4'h5, 16'hAAAA);
      cyc(1'b0, 1'b1, 4'h0, 16'h5555);
      idle_read(4'h2, 2); idle_read(4'h3, 2);
      snap_read();

      // R8: held value unchanged while cells flow
      phase = "R8";
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, (i % 2) ? 4'h3 : 4'h2, 16'h0);

      // R6: long burst, upper byte on u0, ceiling on u1
      phase = "R6";
      for (int i = 0; i < 70000; i++) cyc(1'b1, 1'b0, 4'h2, 16'h0);
      snap_read();
      for (int i = 0; i < 4200; i++) cyc(1'b1, 1'b0, 4'h3, 16'h0);
      snap_read();

      // R5: unused addresses read zero while the buffer is nonzero
      phase = "R5";
      idle_read(4'h3, 1); idle_read(4'h2, 1);
      for (int a = 0; a < 16; a++) idle_read(4'(a), 1);

      finish_run();
   end

endmodule